// File: doc/BRIEF.md
# Per-Pixel Direct/Indexed Colour Selector

This block is one streaming stage of a framebuffer scan-out path. The framebuffer is held as three parallel planes: an 8-bit index plane, a 32-bit direct-colour plane and a 32-bit control plane. For every pixel the upstream fetch logic presents one word from each plane on a single valid/ready input. The block decides where that pixel's colour comes from. It either takes the colour straight from the direct-colour word, or it looks up the 8-bit index in an external palette memory.

The decision is made from the top byte of the control word. When that byte equals a fixed code, the direct colour is used. Any other value falls back to the palette. A build option removes the direct and control planes altogether, and then every pixel goes through the palette. The palette memory answers one cycle after a request. The block therefore holds the direct colour and the decision in a one-entry stage so that they line up with the lookup result. It then presents 24-bit RGB on a valid/ready output.

The stage is controlled by a two-state machine, with the states `ST_EMPTY` and `ST_FULL`. It has these transitions:
- `LOAD` (EMPTY to FULL): a pixel is accepted.
- `PASS` (FULL to FULL): the held pixel leaves and a new one enters on the same edge.
- `HOLD` (FULL to FULL): the output is stalled.
- `DRAIN` (FULL to EMPTY): the held pixel leaves and nothing enters.
- `IDLE` (EMPTY to EMPTY): nothing is accepted.

Top module: `pxsel_top`

## Requirements
- R1: With `HAS_DIRECT`=1, a pixel whose control word has bits 31:24 equal to 8'h03 is output as bits 23:0 of its direct word: red 23:16, green 15:8, blue 7:0.
- R2: A pixel whose control byte (bits 31:24) is any other value is output as the palette data returned for its 8-bit index.
- R3: Bits 31:24 of the direct word have no effect on the output colour.
- R4: A palette request (`pal_rd_en`=1 with `pal_rd_addr` equal to the pixel's index) is issued in exactly the cycle a pixel is accepted. No request is issued while an output pixel is stalled.
- R5: A pixel accepted at a clock edge is presented with `out_valid`=1 right after that edge.
- R6: While `out_valid`=1 and `out_ready`=0, the following conditions hold: `out_valid` stays 1, `out_rgb` stays stable, and `in_ready` is 0.
- R7: Under any pattern of input validity and output back-pressure, every accepted pixel is output exactly once, in order. When a pixel leaves and none enters, `out_valid` drops.
- R8: After reset, `out_valid`=0 and `in_ready`=1.
- R9: With `HAS_DIRECT`=0, every pixel uses the palette path, including pixels whose control byte is 8'h03.
- R10: Only an exact match of the code selects direct colour. Control bytes such as 8'h02, 8'h07 and 8'h83 take the palette path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Stage can accept a pixel |
| in_index | input | 8 | Index-plane byte |
| in_direct | input | 32 | Direct-colour plane word |
| in_ctrl | input | 32 | Control plane word |
| pal_rd_en | output | 1 | Palette lookup request |
| pal_rd_addr | output | 8 | Palette lookup address |
| pal_rd_data | input | 24 | Palette colour, valid the cycle after a request and held until the next one |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts the pixel |
| out_rgb | output | 24 | Output colour, red in 23:16 |

## Verification
A wrong source-select bit held in the stage shows up at once: the output pixel carries the palette colour where the direct colour was due, or the reverse, in the first cycle `out_valid` is high. A stage state that stays FULL or EMPTY when it should not shows within one cycle. It either repeats a pixel or drops one, so the sequence seen at the output drifts against the order of acceptance. A palette request issued during a stall overwrites the held colour, and this is visible on `out_rgb` before the stall ends.

// File: rtl/pxsel_pkg.sv
package pxsel_pkg;
    localparam int unsigned COLOR_W = 24;
    localparam int unsigned TAG_W   = 8;

    typedef logic [COLOR_W-1:0] rgb_t;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } stage_state_t;

    typedef struct packed {
        logic use_direct;
        rgb_t direct_rgb;
    } stage_payload_t;
endpackage

// File: rtl/pxsel_classify.sv
module pxsel_classify
    import pxsel_pkg::*;
#(
    parameter int unsigned WORD_W      = 32,
    parameter bit          HAS_DIRECT  = 1'b1,
    parameter logic [7:0]  DIRECT_CODE = 8'h03
) (
    input  logic [WORD_W-1:0] ctrl_word,
    input  logic [WORD_W-1:0] direct_word,
    output stage_payload_t    payload
);
    localparam int unsigned TAG_LSB = WORD_W - TAG_W;

    generate
        if (HAS_DIRECT) begin : g_direct
            logic [TAG_W-1:0] tag;
            always_comb begin
                tag                = ctrl_word[WORD_W-1:TAG_LSB];
                payload.use_direct = (tag == DIRECT_CODE);
                // top byte of the direct word is discarded here
                payload.direct_rgb = direct_word[COLOR_W-1:0];
            end
        end else begin : g_index_only
            always_comb begin
                payload.use_direct = 1'b0;
                payload.direct_rgb = '0;
            end
        end
    endgenerate
endmodule

// File: rtl/pxsel_stage.sv
module pxsel_stage
    import pxsel_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    output logic           in_ready,
    input  stage_payload_t in_payload,
    output logic           load,
    output logic           out_valid,
    input  logic           out_ready,
    output stage_payload_t out_payload
);
    stage_state_t   state_q, state_d;
    stage_payload_t payload_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (in_valid) state_d = ST_FULL;             // LOAD
            ST_FULL:  if (out_ready && !in_valid) state_d = ST_EMPTY; // DRAIN
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_EMPTY: begin
                in_ready  = 1'b1;
                out_valid = 1'b0;
            end
            ST_FULL: begin
                in_ready  = out_ready;
                out_valid = 1'b1;
            end
            default: begin
                in_ready  = 1'b0;
                out_valid = 1'b0;
            end
        endcase
        load = in_valid && in_ready;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            payload_q <= '0;
        end else if (load) begin
            payload_q <= in_payload;
        end
    end

    assign out_payload = payload_q;

    // R5: an accepted pixel is on the output after the edge
    assert_accept_shows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    // R7: a leaving pixel with no replacement empties the stage
    assert_drain_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !in_valid) |=> !out_valid);

    // R6: a stalled stage keeps its pixel and refuses input
    assert_stall_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(payload_q)));
endmodule

// File: rtl/pxsel_outmux.sv
module pxsel_outmux
    import pxsel_pkg::*;
#(
    parameter bit HAS_DIRECT = 1'b1
) (
    input  stage_payload_t held,
    input  rgb_t           pal_data,
    output rgb_t           rgb
);
    generate
        if (HAS_DIRECT) begin : g_sel
            assign rgb = held.use_direct ? held.direct_rgb : pal_data;
        end else begin : g_pal
            assign rgb = pal_data;
        end
    endgenerate
endmodule

// File: rtl/pxsel_top.sv
module pxsel_top
    import pxsel_pkg::*;
#(
    parameter int unsigned IDX_W       = 8,
    parameter int unsigned WORD_W      = 32,
    parameter bit          HAS_DIRECT  = 1'b1,
    parameter logic [7:0]  DIRECT_CODE = 8'h03
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [IDX_W-1:0]    in_index,
    input  logic [WORD_W-1:0]   in_direct,
    input  logic [WORD_W-1:0]   in_ctrl,
    output logic                pal_rd_en,
    output logic [IDX_W-1:0]    pal_rd_addr,
    input  logic [COLOR_W-1:0]  pal_rd_data,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [COLOR_W-1:0]  out_rgb
);
    stage_payload_t cls_payload;
    stage_payload_t held_payload;
    logic           load;

    pxsel_classify #(
        .WORD_W      (WORD_W),
        .HAS_DIRECT  (HAS_DIRECT),
        .DIRECT_CODE (DIRECT_CODE)
    ) classify_i (
        .ctrl_word   (in_ctrl),
        .direct_word (in_direct),
        .payload     (cls_payload)
    );

    pxsel_stage stage_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_payload  (cls_payload),
        .load        (load),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_payload (held_payload)
    );

    assign pal_rd_en   = load;
    assign pal_rd_addr = in_index;

    pxsel_outmux #(.HAS_DIRECT(HAS_DIRECT)) outmux_i (
        .held     (held_payload),
        .pal_data (pal_rd_data),
        .rgb      (out_rgb)
    );

    // R4: no lookup may overwrite a stalled pixel's palette colour
    assert_no_lookup_in_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !pal_rd_en);

    // R6: output colour is stable while stalled
    assert_rgb_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> $stable(out_rgb));

    generate
        if (!HAS_DIRECT) begin : g_chk_idx
            // R9: index-only build never holds a direct-selected pixel
            assert_index_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid |-> !held_payload.use_direct);
        end
    endgenerate
endmodule

// File: tb/pxsel_top_tb_top.sv
module pxsel_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_index = '0;
    logic [31:0] in_direct = '0;
    logic [31:0] in_ctrl = '0;
    logic        out_ready = 1'b0;

    logic        in_ready, pal_rd_en, out_valid;
    logic [7:0]  pal_rd_addr;
    logic [23:0] pal_q, out_rgb;
    logic        in_ready8, pal_rd_en8, out_valid8;
    logic [7:0]  pal_rd_addr8;
    logic [23:0] pal_q8, out_rgb8;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    function automatic logic [23:0] pal_of(input logic [7:0] a);
        return {a, a ^ 8'hFF, a ^ 8'h5A};
    endfunction

    always_ff @(posedge clk) if (pal_rd_en)  pal_q  <= pal_of(pal_rd_addr);
    always_ff @(posedge clk) if (pal_rd_en8) pal_q8 <= pal_of(pal_rd_addr8);

    pxsel_top dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_index(in_index), .in_direct(in_direct), .in_ctrl(in_ctrl),
        .pal_rd_en(pal_rd_en), .pal_rd_addr(pal_rd_addr), .pal_rd_data(pal_q),
        .out_valid(out_valid), .out_ready(out_ready), .out_rgb(out_rgb)
    );

    pxsel_top #(.HAS_DIRECT(1'b0)) dut8_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready8),
        .in_index(in_index), .in_direct(in_direct), .in_ctrl(in_ctrl),
        .pal_rd_en(pal_rd_en8), .pal_rd_addr(pal_rd_addr8), .pal_rd_data(pal_q8),
        .out_valid(out_valid8), .out_ready(out_ready), .out_rgb(out_rgb8)
    );

    typedef struct packed {
        logic [7:0]  idx;
        logic [31:0] ctrl;
        logic [31:0] dir;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        {8'h10, 32'h0300_0000, 32'hFF12_3456},
        {8'h20, 32'h0000_0000, 32'h0011_2233},
        {8'h30, 32'h02FF_FFFF, 32'h00AA_BBCC},
        {8'h40, 32'h8300_0000, 32'h0001_0203},
        {8'hFF, 32'h03AB_CDEF, 32'h00AB_CDEF},
        {8'h00, 32'h0400_0003, 32'h0300_0000},
        {8'h7E, 32'h0300_FFFF, 32'h7F00_0000},
        {8'h55, 32'h0700_0000, 32'h0099_8877}
    };

    function automatic logic [23:0] expect_rgb(input vec_t v, input bit has_dir);
        if (has_dir && v.ctrl[31:24] == 8'h03) return v.dir[23:0];
        return pal_of(v.idx);
    endfunction

    function automatic vec_t gen(input int k);
        vec_t v;
        v.idx  = 8'(k * 37 + 3);
        v.ctrl = (k % 3 == 0) ? 32'h0300_0000 : {8'(k), 24'h0};
        v.dir  = {8'(k ^ 8'hA5), 8'(k * 5), 8'(k * 11), 8'(k)};
        return v;
    endfunction

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        in_index  = v.idx;
        in_ctrl   = v.ctrl;
        in_direct = v.dir;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%h expected=%h", 24'h0, 24'h1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state
        check("R8 out_valid", {23'h0, out_valid}, 24'h0);
        check("R8 in_ready",  {23'h0, in_ready},  24'h1);

        // vector table walk: R1 R2 R3 R4 R5 R9 R10
        for (int i = 0; i < NV; i++) begin
            out_ready = 1'b1;
            drive(VECS[i]);
            in_valid = 1'b1;
            #1;
            check("R4 rd_en",   {23'h0, pal_rd_en}, 24'h1);
            check("R4 rd_addr", {16'h0, pal_rd_addr}, {16'h0, VECS[i].idx});
            @(negedge clk);
            in_valid = 1'b0;
            #1;
            check("R5 out_valid", {23'h0, out_valid}, 24'h1);
            check("R1/R2/R3/R10 rgb", out_rgb, expect_rgb(VECS[i], 1'b1));
            check("R9 index-only rgb", out_rgb8, expect_rgb(VECS[i], 1'b0));
            @(negedge clk);
            check("R7 drained", {23'h0, out_valid}, 24'h0);
        end

        // R6: back-pressure holds the pixel and blocks input
        out_ready = 1'b0;
        drive(VECS[0]);
        in_valid = 1'b1;
        @(negedge clk);
        drive(VECS[1]);
        for (int c = 0; c < 4; c++) begin
            #1;
            check("R6 in_ready low", {23'h0, in_ready}, 24'h0);
            check("R4 no lookup in stall", {23'h0, pal_rd_en}, 24'h0);
            check("R6 rgb held", out_rgb, expect_rgb(VECS[0], 1'b1));
            check("R6 valid held", {23'h0, out_valid}, 24'h1);
            @(negedge clk);
        end
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        check("R7 next after stall", out_rgb, expect_rgb(VECS[1], 1'b1));
        @(negedge clk);
        check("R7 empty after stall", {23'h0, out_valid}, 24'h0);

        // R7: streaming with mixed gaps and back-pressure
        begin
            int snt = 0;
            int rcv = 0;
            for (int cyc = 0; cyc < 200 && rcv < 40; cyc++) begin
                out_ready = ((cyc % 5) != 2) && ((cyc % 7) != 4);
                in_valid  = (snt < 40) && ((cyc % 6) != 3);
                drive(gen(snt));
                #1;
                if (out_valid && out_ready) begin
                    check("R7 stream order", out_rgb, expect_rgb(gen(rcv), 1'b1));
                    check("R9 stream index-only", out_rgb8, expect_rgb(gen(rcv), 1'b0));
                    rcv++;
                end
                if (in_valid && in_ready) snt++;
                @(negedge clk);
            end
            in_valid = 1'b0;
            check("R7 stream count", 24'(rcv), 24'd40);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule